// File: doc/BRIEF.md
# Per-Drive Recording Mode Register

This block holds the recording-mode setting of a disk controller that serves up to four drives. A decoded command byte, presented with a one-cycle valid strobe, loads two global mode bits (a gap-select bit and a write-gate bit) and, under an overwrite flag, one perpendicular-enable bit per drive. When either global bit is set, the global pair alone decides the behaviour of every drive. When both are clear, each drive's own bit decides: a set bit makes that drive perpendicular, with precompensation forced to zero, and a clear bit leaves it conventional.

For the drive named by the drive select input, the block presents the effective mode bits, a flag showing that the per-drive perpendicular rule applies, the GAP2 length (looked up from the data rate code), and the precompensation value to use. All of these are registered. The stored bits are also presented at once as a readback field for the controller's register dump. A software reset clears only the global bits. The asynchronous hardware reset clears everything.

Top module: `perp_mode_reg`

## Requirements
- R1: While the stored gap or write-gate bit is 1, the selected drive's effective mode equals the stored global pair, the per-drive flag is 0, precompensation equals the programmed value, and the drive bits have no effect.
- R2: While both global bits are 0 and the selected drive's bit is 1, both effective mode bits are 1, the per-drive flag is 1, and the precompensation output is 0.
- R3: While both global bits are 0 and the selected drive's bit is 0, both effective mode bits and the flag are 0, and precompensation equals the programmed value.
- R4: The command byte has the overwrite flag in bit 7, drive bits 3..0 in bits 5..2, gap in bit 1 and write-gate in bit 0. A valid command always loads gap and write-gate. It loads the drive bits only when bit 7 is 1.
- R5: A software reset clears gap and write-gate and keeps the drive bits. It takes priority over a command in the same cycle.
- R6: A low hardware reset clears all stored bits at once, without waiting for a clock edge. It drives the mode outputs and the precompensation output to 0 and sets the GAP2 length to the conventional value of 27. It takes priority over any command.
- R7: When the effective gap bit is 1, the GAP2 length is taken from the data rate code: code 0 gives 20, 1 gives 22, 2 gives 30 and 3 gives 41. Otherwise it is the conventional value 27.
- R8: The readback field carries drive bits 3..0 in bits 5..2, gap in bit 1 and write-gate in bit 0. It shows the new values right after the edge that stores them.
- R9: The selected-drive outputs are registered. Each reflects the stored state and the inputs as they stood at the previous clock edge, so a command or a change of drive select shows one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Decoded command data byte |
| drive_sel | input | 2 | Selected drive |
| precomp_in | input | 3 | Programmed precompensation value |
| rate_code | input | 2 | Data rate code |
| mode_gap | output | 1 | Effective gap bit of the selected drive |
| mode_wgate | output | 1 | Effective write-gate bit of the selected drive |
| perp_drive | output | 1 | Per-drive perpendicular rule in force |
| gap2_len | output | 8 | GAP2 length for the selected drive |
| precomp_out | output | 3 | Precompensation value to apply |
| rdbk | output | 6 | Readback of the stored bits |

## Verification
The readback field changes at the same edge that stores a command or applies a software reset. The bench therefore compares it against its model state right after that edge. The selected-drive outputs come one register later: the bench computes their expected values from its model state and the inputs as they stood before the edge, then compares them at the following falling edge. A directed step changes the drive select and confirms that the outputs do not move until the next rising edge. The hardware reset is checked in the middle of the low pulse, before any clock edge has passed.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
   localparam int CMD_W      = 8;
   localparam int OW_POS     = 7;
   localparam int GAP_POS    = 1;
   localparam int WGATE_POS  = 0;
   localparam int DRV_LSB    = 2;
   localparam int MAX_DRIVES = 4;

   typedef struct packed {
      logic gap;
      logic wgate;
   } glob_mode_t;

   typedef struct packed {
      logic gap;
      logic wgate;
      logic by_drive;
   } eff_mode_t;
endpackage

// File: rtl/pmr_cfg_store.sv
module pmr_cfg_store
   import pmr_pkg::*;
#(
   parameter int NUM_DRIVES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sw_rst,
   input  logic                  cmd_valid,
   input  logic [CMD_W-1:0]      cmd_byte,
   output glob_mode_t            glob_q,
   output logic [NUM_DRIVES-1:0] drv_q
);
   logic overwrite;
   assign overwrite = cmd_byte[OW_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_q <= '0;
      end else if (sw_rst) begin
         glob_q <= '0;
      end else if (cmd_valid) begin
         glob_q.gap   <= cmd_byte[GAP_POS];
         glob_q.wgate <= cmd_byte[WGATE_POS];
      end
   end

   for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            drv_q[d] <= 1'b0;
         end else if (cmd_valid && overwrite && !sw_rst) begin
            drv_q[d] <= cmd_byte[DRV_LSB+d];
         end
      end
   end
endmodule

// File: rtl/pmr_drive_resolve.sv
module pmr_drive_resolve
   import pmr_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int DSEL_W     = 2
) (
   input  glob_mode_t            glob_q,
   input  logic [NUM_DRIVES-1:0] drv_q,
   input  logic [DSEL_W-1:0]     drive_sel,
   output eff_mode_t             eff
);
   eff_mode_t per_drive [NUM_DRIVES];
   logic      glob_any;

   assign glob_any = glob_q.gap | glob_q.wgate;

   for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_res
      always_comb begin
         if (glob_any) begin
            per_drive[d].gap      = glob_q.gap;
            per_drive[d].wgate    = glob_q.wgate;
            per_drive[d].by_drive = 1'b0;
         end else begin
            per_drive[d].gap      = drv_q[d];
            per_drive[d].wgate    = drv_q[d];
            per_drive[d].by_drive = drv_q[d];
         end
      end
   end

   always_comb begin
      eff = per_drive[0];
      for (int d = 0; d < NUM_DRIVES; d++) begin
         if (drive_sel == DSEL_W'(d)) eff = per_drive[d];
      end
   end
endmodule

// File: rtl/pmr_out_stage.sv
module pmr_out_stage
   import pmr_pkg::*;
#(
   parameter int PRECOMP_W = 3,
   parameter int RATE_W    = 2,
   parameter int GAP2_W    = 8,
   parameter logic [(2**RATE_W)*GAP2_W-1:0] GAP2_TABLE = {8'd41, 8'd30, 8'd22, 8'd20},
   parameter logic [GAP2_W-1:0] GAP2_CONV = 8'd27
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  eff_mode_t            eff,
   input  logic [PRECOMP_W-1:0] precomp_in,
   input  logic [RATE_W-1:0]    rate_code,
   output logic                 mode_gap,
   output logic                 mode_wgate,
   output logic                 perp_drive,
   output logic [GAP2_W-1:0]    gap2_len,
   output logic [PRECOMP_W-1:0] precomp_out
);
   localparam int N_RATES = 2 ** RATE_W;

   logic [GAP2_W-1:0] rate_len [N_RATES];
   logic [GAP2_W-1:0] looked_up;
   logic [GAP2_W-1:0] gap2_d;
   logic [PRECOMP_W-1:0] precomp_d;

   for (genvar r = 0; r < N_RATES; r++) begin : g_tab
      assign rate_len[r] = GAP2_TABLE[r*GAP2_W +: GAP2_W];
   end

   always_comb begin
      looked_up = rate_len[0];
      for (int r = 0; r < N_RATES; r++) begin
         if (rate_code == RATE_W'(r)) looked_up = rate_len[r];
      end
   end

   assign gap2_d    = eff.gap ? looked_up : GAP2_CONV;
   assign precomp_d = eff.by_drive ? '0 : precomp_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_gap    <= 1'b0;
         mode_wgate  <= 1'b0;
         perp_drive  <= 1'b0;
         gap2_len    <= GAP2_CONV;
         precomp_out <= '0;
      end else begin
         mode_gap    <= eff.gap;
         mode_wgate  <= eff.wgate;
         perp_drive  <= eff.by_drive;
         gap2_len    <= gap2_d;
         precomp_out <= precomp_d;
      end
   end
endmodule

// File: rtl/perp_mode_reg.sv
module perp_mode_reg
   import pmr_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int PRECOMP_W  = 3,
   parameter int RATE_W     = 2,
   parameter int GAP2_W     = 8,
   parameter logic [(2**RATE_W)*GAP2_W-1:0] GAP2_TABLE = {8'd41, 8'd30, 8'd22, 8'd20},
   parameter logic [GAP2_W-1:0] GAP2_CONV = 8'd27,
   localparam int DSEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
   localparam int RB_W   = DRV_LSB + NUM_DRIVES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_rst,
   input  logic                 cmd_valid,
   input  logic [7:0]           cmd_byte,
   input  logic [DSEL_W-1:0]    drive_sel,
   input  logic [PRECOMP_W-1:0] precomp_in,
   input  logic [RATE_W-1:0]    rate_code,
   output logic                 mode_gap,
   output logic                 mode_wgate,
   output logic                 perp_drive,
   output logic [GAP2_W-1:0]    gap2_len,
   output logic [PRECOMP_W-1:0] precomp_out,
   output logic [RB_W-1:0]      rdbk
);
   if (NUM_DRIVES < 1 || NUM_DRIVES > MAX_DRIVES) begin : g_bad_drives
      $error("perp_mode_reg: NUM_DRIVES must be 1 to 4");
   end
   if (PRECOMP_W < 1 || RATE_W < 1 || GAP2_W < 1) begin : g_bad_widths
      $error("perp_mode_reg: widths must be positive");
   end

   glob_mode_t            glob_q;
   logic [NUM_DRIVES-1:0] drv_q;
   eff_mode_t             eff;

   pmr_cfg_store #(.NUM_DRIVES(NUM_DRIVES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_rst    (sw_rst),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .glob_q    (glob_q),
      .drv_q     (drv_q)
   );

   pmr_drive_resolve #(.NUM_DRIVES(NUM_DRIVES), .DSEL_W(DSEL_W)) u_resolve (
      .glob_q    (glob_q),
      .drv_q     (drv_q),
      .drive_sel (drive_sel),
      .eff       (eff)
   );

   pmr_out_stage #(
      .PRECOMP_W  (PRECOMP_W),
      .RATE_W     (RATE_W),
      .GAP2_W     (GAP2_W),
      .GAP2_TABLE (GAP2_TABLE),
      .GAP2_CONV  (GAP2_CONV)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .eff         (eff),
      .precomp_in  (precomp_in),
      .rate_code   (rate_code),
      .mode_gap    (mode_gap),
      .mode_wgate  (mode_wgate),
      .perp_drive  (perp_drive),
      .gap2_len    (gap2_len),
      .precomp_out (precomp_out)
   );

   assign rdbk = {drv_q, glob_q.gap, glob_q.wgate};
endmodule

// File: rtl/pmr_chk.sv
module pmr_chk #(
   parameter int NUM_DRIVES = 4,
   parameter int PRECOMP_W  = 3,
   parameter int DSEL_W     = 2,
   parameter int RB_W       = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sw_rst,
   input logic                 cmd_valid,
   input logic [7:0]           cmd_byte,
   input logic [DSEL_W-1:0]    drive_sel,
   input logic [PRECOMP_W-1:0] precomp_in,
   input logic                 mode_gap,
   input logic                 mode_wgate,
   input logic                 perp_drive,
   input logic [PRECOMP_W-1:0] precomp_out,
   input logic [RB_W-1:0]      rdbk
);
   logic [NUM_DRIVES-1:0] drv_view;
   logic                  glob_any;
   logic                  sel_bit;

   assign drv_view = rdbk[RB_W-1:2];
   assign glob_any = |rdbk[1:0];
   assign sel_bit  = drv_view[drive_sel];

   AST_GLOBAL_RULES: assert property (@(posedge clk) disable iff (!rst_n)
      glob_any |=> ({mode_gap, mode_wgate} == $past(rdbk[1:0])) && !perp_drive
                   && (precomp_out == $past(precomp_in))); // R1

   AST_PERP_NO_PRECOMP: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_any && sel_bit) |=> perp_drive && mode_gap && mode_wgate
                                 && (precomp_out == '0)); // R2

   AST_CONV_PRECOMP: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_any && !sel_bit) |=> !perp_drive && !mode_gap
                                  && (precomp_out == $past(precomp_in))); // R3

   AST_OW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_byte[7]) |=> $stable(drv_view)); // R4

   AST_CMD_GLOBALS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !sw_rst) |=> (rdbk[1:0] == $past(cmd_byte[1:0]))); // R4

   AST_SWRST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (rdbk[1:0] == 2'b00) && $stable(drv_view)); // R5

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         AST_HW_CLEAR: assert (rdbk == '0 && !perp_drive && precomp_out == '0); // R6
      end
   end
endmodule

bind perp_mode_reg pmr_chk #(
   .NUM_DRIVES (NUM_DRIVES),
   .PRECOMP_W  (PRECOMP_W),
   .DSEL_W     (DSEL_W),
   .RB_W       (RB_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sw_rst      (sw_rst),
   .cmd_valid   (cmd_valid),
   .cmd_byte    (cmd_byte),
   .drive_sel   (drive_sel),
   .precomp_in  (precomp_in),
   .mode_gap    (mode_gap),
   .mode_wgate  (mode_wgate),
   .perp_drive  (perp_drive),
   .precomp_out (precomp_out),
   .rdbk        (rdbk)
);

// File: tb/perp_mode_reg_tb_top.sv
module perp_mode_reg_tb_top;
   logic       clk;
   logic       rst_n;
   logic       sw_rst;
   logic       cmd_valid;
   logic [7:0] cmd_byte;
   logic [1:0] drive_sel;
   logic [2:0] precomp_in;
   logic [1:0] rate_code;
   logic       mode_gap, mode_wgate, perp_drive;
   logic [7:0] gap2_len;
   logic [2:0] precomp_out;
   logic [5:0] rdbk;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   // model state
   logic       m_gap, m_wg;
   logic [3:0] m_drv;
   // expected registered outputs
   logic       e_gap, e_wg, e_perp;
   logic [7:0] e_len;
   logic [2:0] e_pc;
   string      e_tag;

   perp_mode_reg dut_i (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cmd_valid(cmd_valid),
      .cmd_byte(cmd_byte), .drive_sel(drive_sel), .precomp_in(precomp_in),
      .rate_code(rate_code), .mode_gap(mode_gap), .mode_wgate(mode_wgate),
      .perp_drive(perp_drive), .gap2_len(gap2_len), .precomp_out(precomp_out),
      .rdbk(rdbk)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   function automatic logic [7:0] rate_len(input logic [1:0] rc);
      case (rc)
         2'd0: return 8'd20;
         2'd1: return 8'd22;
         2'd2: return 8'd30;
         default: return 8'd41;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // expected outputs from model state and current inputs (R1, R2, R3, R7)
   task automatic predict();
      if (m_gap || m_wg) begin
         e_gap = m_gap; e_wg = m_wg; e_perp = 1'b0; e_pc = precomp_in; e_tag = "R1";
      end else if (m_drv[drive_sel]) begin
         e_gap = 1'b1; e_wg = 1'b1; e_perp = 1'b1; e_pc = 3'd0; e_tag = "R2";
      end else begin
         e_gap = 1'b0; e_wg = 1'b0; e_perp = 1'b0; e_pc = precomp_in; e_tag = "R3";
      end
      e_len = e_gap ? rate_len(rate_code) : 8'd27;
   endtask

   // model update (R4, R5)
   task automatic update_model();
      if (sw_rst) begin
         m_gap = 1'b0; m_wg = 1'b0;
      end else if (cmd_valid) begin
         m_gap = cmd_byte[1]; m_wg = cmd_byte[0];
         if (cmd_byte[7]) m_drv = cmd_byte[5:2];
      end
   endtask

   task automatic compare_all(input string rb_tag);
      check(e_tag, int'(mode_gap), int'(e_gap));
      check(e_tag, int'(mode_wgate), int'(e_wg));
      check(e_tag, int'(perp_drive), int'(e_perp));
      check(e_tag, int'(precomp_out), int'(e_pc));
      check("R7", int'(gap2_len), int'(e_len));
      check(rb_tag, int'(rdbk), int'({m_drv, m_gap, m_wg}));
   endtask

   // one clock: inputs set at falling edge, compared at the next falling edge (R9)
   task automatic cycle(input logic v, input logic [7:0] b, input logic s,
                        input logic [1:0] ds, input logic [2:0] pc, input logic [1:0] rc);
      string rb_tag;
      cmd_valid = v; cmd_byte = b; sw_rst = s;
      drive_sel = ds; precomp_in = pc; rate_code = rc;
      rb_tag = s ? "R5" : (v ? "R4" : "R8");
      predict();
      update_model();
      @(posedge clk);
      @(negedge clk);
      compare_all(rb_tag);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20251));
      rst_n = 1'b0;
      sw_rst = 1'b0; cmd_valid = 1'b0; cmd_byte = '0;
      drive_sel = '0; precomp_in = 3'd5; rate_code = '0;
      m_gap = 0; m_wg = 0; m_drv = '0;
      repeat (3) @(negedge clk);
      // reset state (R6)
      check("R6", int'(rdbk), 0);
      check("R6", int'(gap2_len), 27);
      check("R6", int'(precomp_out), 0);
      rst_n = 1'b1;

      // load drive bits with OW: drives 1 and 3 perpendicular (R4, R8)
      cycle(1, 8'b1010_1000, 0, 2'd0, 3'd5, 2'd2);
      // output reflects command one clock later (R9): check drives
      for (int d = 0; d < 4; d++) cycle(0, 8'h00, 0, 2'(d), 3'd6, 2'(d));
      // OW = 0 must leave drive bits unchanged, global gap loaded (R4)
      cycle(1, 8'b0011_1110, 0, 2'd1, 3'd4, 2'd3);
      cycle(0, 8'h00, 0, 2'd1, 3'd4, 2'd3);
      check("R4", int'(rdbk[5:2]), 4'b1010);
      // global write-gate only: drive bits ignored (R1)
      cycle(1, 8'b0000_0001, 0, 2'd3, 3'd2, 2'd0);
      cycle(0, 8'h00, 0, 2'd3, 3'd2, 2'd0);
      // software reset with simultaneous command (R5)
      cycle(1, 8'b1000_0011, 1, 2'd3, 3'd7, 2'd1);
      check("R5", int'(rdbk), int'({4'b1010, 2'b00}));
      cycle(0, 8'h00, 0, 2'd3, 3'd7, 2'd1);
      check("R2", int'(precomp_out), 0);

      // drive select change not visible before the next rising edge (R9)
      drive_sel = 2'd0;
      #1;
      check("R9", int'(perp_drive), 1);
      cycle(0, 8'h00, 0, 2'd0, 3'd7, 2'd1);
      check("R9", int'(perp_drive), 0);

      // random mix
      for (int i = 0; i < 1500; i++) begin
         logic [7:0] b;
         b = 8'($urandom);
         b[6] = 1'b0;
         if ($urandom % 2 == 0) b[1:0] = 2'b00;
         cycle(($urandom % 3) != 0, b, ($urandom % 16) == 0,
               2'($urandom), 3'($urandom), 2'($urandom));
      end

      // hardware reset mid-run with a command present (R6)
      cycle(1, 8'b1011_1100, 0, 2'd2, 3'd3, 2'd0);
      cmd_valid = 1'b1; cmd_byte = 8'b1011_1111;
      rst_n = 1'b0;
      #2;
      check("R6", int'(rdbk), 0);
      check("R6", int'(perp_drive), 0);
      check("R6", int'(precomp_out), 0);
      check("R6", int'(gap2_len), 27);
      @(negedge clk);
      check("R6", int'(rdbk), 0);
      m_gap = 0; m_wg = 0; m_drv = '0;
      rst_n = 1'b1;
      cycle(0, 8'h00, 0, 2'd2, 3'd3, 2'd0);
      cycle(0, 8'h00, 0, 2'd2, 3'd3, 2'd0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule